// File: doc/BRIEF.md
# HDLC Channel Interrupt and Status Unit

This block is the host-side interrupt and status logic for one HDLC data channel. Single-cycle event pulses come in from the transmit FIFO and the receiver. Each pulse is latched into a pending interrupt register. A per-bit mask register decides which pending bits the host can see and which ones drive the single interrupt line.

A host read of the interrupt register returns only the visible pending bits and clears exactly those bits. Masked events are kept and show up as soon as their mask bit is cleared. A transmit underrun locks the transmit FIFO. The lock stays until the host has actually read the underrun bit. If the underrun is masked, it cannot be read, so the FIFO stays locked until the bit is unmasked and read.

Next to the interrupt path, the block keeps a live, read-only status word with three bits:
- a transmit overflow flag, set when the host writes more bytes than the selected 16- or 32-byte block holds;
- a write-enable flag the host can poll instead of waiting for the transmit-ready interrupt;
- a receiver-active flag that follows opening flags and abort sequences on the line.

Top module: `hdlc_chan_irq`

## Requirements
- R1: After reset the mask register is 0xFF, nothing is pending, `irq_o` and `tx_lock_o` are 0, `isr_rdata_o` is 0 and `stat_o` is 0x40.
- R2: An event pulse on `ev_i` sets the pending bit of the same index on the next clock edge. Event indices are: 0 transmit ready, 1 transmit underrun, 2 message repeat, 3 overflow, 4 receive message end, 5 receive pool full. The bit stays pending until a host read clears it, even while it is masked.
- R3: `isr_rdata_o` always shows the pending bits whose mask bit is 0. A one-cycle `isr_rd_i` strobe clears exactly the bits shown in that cycle. Masked pending bits are kept.
- R4: `irq_o` is high exactly when at least one pending bit has its mask bit at 0.
- R5: Writing a 0 into the mask bit of a pending event makes that event visible in `isr_rdata_o` and raises `irq_o` on the cycle after the write.
- R6: If an event arrives in the same cycle as a read that clears its bit, the event wins and the bit stays pending.
- R7: An underrun event (index 1) sets `tx_lock_o` on the next edge. The lock clears only after a read that shows the underrun bit, and only if no new underrun arrives in that same cycle. A read done while the underrun is masked leaves the lock set.
- R8: `stat_o[7]` (overflow) sets when a byte is written (`tx_wr_i`) while the written-byte count already equals the block size: 16 when `tx_blk32_i` is 0, 32 when it is 1. It is cleared only by `tx_reset_i`, which also zeroes the count. A transmit-ready event (index 0) zeroes the count but leaves the overflow flag alone.
- R9: `stat_o[6]` (write enable) is high when the byte count is below the current block size and the FIFO is not locked.
- R10: `stat_o[5]` (receiver active) sets on `rx_flag_i` and clears on `rx_abort_i`. If both arrive in the same cycle, the abort wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_i | input | EV_W (6) | One-cycle event pulses, one bit per source |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | REG_W (8) | Mask write data, 1 = hidden |
| isr_rd_i | input | 1 | Interrupt register read strobe, clears the shown bits |
| isr_rdata_o | output | REG_W (8) | Visible pending bits |
| irq_o | output | 1 | Interrupt request |
| tx_lock_o | output | 1 | Transmit FIFO lock |
| tx_wr_i | input | 1 | One byte written into the transmit FIFO |
| tx_blk32_i | input | 1 | Block size select: 0 = 16 bytes, 1 = 32 bytes |
| tx_reset_i | input | 1 | Transmitter reset strobe |
| rx_flag_i | input | 1 | Opening flag detected by the receiver |
| rx_abort_i | input | 1 | Abort sequence detected by the receiver |
| stat_o | output | REG_W (8) | Status word: bit 7 overflow, bit 6 write enable, bit 5 receiver active |

## Verification
The in-RTL assertions check these rules on every cycle:
- every event is latched;
- a read never drops a masked pending bit and always clears the bits it showed;
- the FIFO lock follows any underrun and survives any cycle that cannot release it;
- the overflow flag is sticky and the byte count stays bounded;
- an abort always drops the receiver-active flag.

The bench's scenarios cover the behaviours that depend on order and history:
- an event hidden by the reset mask, then surfacing when unmasked;
- a masked underrun holding the lock across a read;
- an event or underrun racing a clearing read;
- the block-size switch between 16 and 32 bytes at a full count;
- a transmit-ready event freeing space without clearing overflow.

// File: rtl/hdlc_irq_pkg.sv
package hdlc_irq_pkg;
  // register and event widths
  localparam int ISR_W = 8;
  localparam int NUM_EV = 6;

  // event indices into the pending register
  localparam int EV_TXRDY = 0;
  localparam int EV_UNDR  = 1;
  localparam int EV_REPT  = 2;
  localparam int EV_OVFL  = 3;
  localparam int EV_RMEND = 4;
  localparam int EV_RFULL = 5;

  // status word bit positions
  localparam int ST_OVF = 7;
  localparam int ST_WEN = 6;
  localparam int ST_ACT = 5;

  // transmit block sizes in bytes
  localparam int BLK_SMALL = 16;
  localparam int BLK_LARGE = 32;
endpackage

// File: rtl/hdlc_rst_sync.sv
module hdlc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/hdlc_irq_latch.sv
module hdlc_irq_latch #(
  parameter int REG_W   = 8,
  parameter int EV_W    = 6,
  parameter int UDR_IDX = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  ev_i,
  input  logic             mask_wr_i,
  input  logic [REG_W-1:0] mask_wdata_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] shown_o,
  output logic             irq_o,
  output logic             lock_o
);
  logic [REG_W-1:0] pend_q, pend_d;
  logic [REG_W-1:0] mask_q, mask_d;
  logic [REG_W-1:0] ev_ext, shown, clr;
  logic             mask_en;
  logic             lock_q, lock_d;

  assign ev_ext  = REG_W'(ev_i);
  assign shown   = pend_q & ~mask_q;
  assign clr     = rd_i ? shown : '0;
  assign mask_en = mask_wr_i;

  // per-bit pending update: a new event beats a clearing read
  for (genvar g = 0; g < REG_W; g++) begin : g_pend
    assign pend_d[g] = ev_ext[g] | (pend_q[g] & ~clr[g]);
  end

  always_comb begin
    mask_d = mask_q;
    if (mask_en) mask_d = mask_wdata_i;
  end

  always_comb begin
    lock_d = lock_q;
    if (ev_ext[UDR_IDX])                lock_d = 1'b1;
    else if (rd_i && shown[UDR_IDX])    lock_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      lock_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (mask_en) mask_q <= mask_d;
      lock_q <= lock_d;
    end
  end

  assign shown_o = shown;
  assign irq_o   = |shown;
  assign lock_o  = lock_q;

  assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((pend_q & $past(ev_ext)) == $past(ev_ext)));

  assert_masked_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> ((pend_q & $past(pend_q & mask_q)) == $past(pend_q & mask_q)));

  assert_shown_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && ev_i == '0) |=> ((pend_q & $past(shown_o)) == '0));

  assert_all_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq_o);

  assert_lock_on_underrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i[UDR_IDX] |=> lock_o);

  assert_lock_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !(rd_i && !mask_q[UDR_IDX])) |=> lock_o);
endmodule

// File: rtl/hdlc_tx_fill.sv
module hdlc_tx_fill #(
  parameter int BLK_S = 16,
  parameter int BLK_L = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic blk_sel_i,
  input  logic pool_clr_i,
  input  logic tx_reset_i,
  input  logic lock_i,
  output logic ovf_o,
  output logic wen_o
);
  localparam int CNT_W = $clog2(BLK_L + 1);
  localparam logic [CNT_W-1:0] SZ_S = CNT_W'(BLK_S);
  localparam logic [CNT_W-1:0] SZ_L = CNT_W'(BLK_L);

  logic [CNT_W-1:0] cnt_q, cnt_d, base, size;
  logic             ovf_q, ovf_d;
  logic             cnt_en;

  assign size   = blk_sel_i ? SZ_L : SZ_S;
  assign base   = pool_clr_i ? '0 : cnt_q;
  assign cnt_en = tx_reset_i | wr_i | pool_clr_i;

  always_comb begin
    cnt_d = base;
    ovf_d = ovf_q;
    if (tx_reset_i) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (wr_i) begin
      if (base >= size) ovf_d = 1'b1;
      else              cnt_d = base + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign ovf_o = ovf_q;
  assign wen_o = (cnt_q < size) && !lock_i;

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !tx_reset_i) |=> ovf_o);

  assert_full_write_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !tx_reset_i && !pool_clr_i && cnt_q >= size) |=> ovf_o);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SZ_L);

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset_i |=> (!ovf_o && cnt_q == '0));
endmodule

// File: rtl/hdlc_rx_activity.sv
module hdlc_rx_activity (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  input  logic abort_i,
  output logic act_o
);
  logic act_q, act_d, act_en;

  assign act_en = flag_i | abort_i;

  always_comb begin
    act_d = act_q;
    if (abort_i)     act_d = 1'b0;
    else if (flag_i) act_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_q <= 1'b0;
    else if (act_en) act_q <= act_d;
  end

  assign act_o = act_q;

  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !act_o);

  assert_flag_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i && !abort_i) |=> act_o);
endmodule

// File: rtl/hdlc_chan_irq.sv
module hdlc_chan_irq
  import hdlc_irq_pkg::*;
#(
  parameter int REG_W = ISR_W,
  parameter int EV_W  = NUM_EV,
  parameter int BLK_S = BLK_SMALL,
  parameter int BLK_L = BLK_LARGE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_W-1:0]  ev_i,
  input  logic             mask_wr_i,
  input  logic [REG_W-1:0] mask_wdata_i,
  input  logic             isr_rd_i,
  output logic [REG_W-1:0] isr_rdata_o,
  output logic             irq_o,
  output logic             tx_lock_o,
  input  logic             tx_wr_i,
  input  logic             tx_blk32_i,
  input  logic             tx_reset_i,
  input  logic             rx_flag_i,
  input  logic             rx_abort_i,
  output logic [REG_W-1:0] stat_o
);
  logic srst_n;
  logic lock, ovf, wen, act;

  hdlc_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  hdlc_irq_latch #(
    .REG_W   (REG_W),
    .EV_W    (EV_W),
    .UDR_IDX (EV_UNDR)
  ) u_latch (
    .clk          (clk),
    .rst_n        (srst_n),
    .ev_i         (ev_i),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .rd_i         (isr_rd_i),
    .shown_o      (isr_rdata_o),
    .irq_o        (irq_o),
    .lock_o       (lock)
  );

  hdlc_tx_fill #(
    .BLK_S (BLK_S),
    .BLK_L (BLK_L)
  ) u_fill (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_i       (tx_wr_i),
    .blk_sel_i  (tx_blk32_i),
    .pool_clr_i (ev_i[EV_TXRDY]),
    .tx_reset_i (tx_reset_i),
    .lock_i     (lock),
    .ovf_o      (ovf),
    .wen_o      (wen)
  );

  hdlc_rx_activity u_rx (
    .clk     (clk),
    .rst_n   (srst_n),
    .flag_i  (rx_flag_i),
    .abort_i (rx_abort_i),
    .act_o   (act)
  );

  always_comb begin
    stat_o         = '0;
    stat_o[ST_OVF] = ovf;
    stat_o[ST_WEN] = wen;
    stat_o[ST_ACT] = act;
  end

  assign tx_lock_o = lock;

  assert_lock_blocks_write_R9: assert property (@(posedge clk) disable iff (!srst_n)
    tx_lock_o |-> !stat_o[ST_WEN]);
endmodule

// File: tb/sim_hdlc_chan_irq.sv
`timescale 1ns/1ps
module sim_hdlc_chan_irq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] ev;
  logic       mwr, rd, twr, blk, trst, rflag, rabort;
  logic [7:0] mdat;
  logic [7:0] rdata, stat;
  logic       irq, lock;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] got;

  always #2 clk = ~clk;

  hdlc_chan_irq u0 (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .mask_wr_i(mwr), .mask_wdata_i(mdat),
    .isr_rd_i(rd), .isr_rdata_o(rdata), .irq_o(irq), .tx_lock_o(lock),
    .tx_wr_i(twr), .tx_blk32_i(blk), .tx_reset_i(trst),
    .rx_flag_i(rflag), .rx_abort_i(rabort), .stat_o(stat)
  );

  // behavioural reference model
  logic [7:0] m_pend, m_mask;
  bit m_lock, m_ovf, m_act;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 8'h00; m_mask = 8'hFF; m_lock = 0;
      m_cnt = 0; m_ovf = 0; m_act = 0;
    end else begin
      logic [7:0] vis;
      int c, sz;
      vis = m_pend & ~m_mask;
      if (ev[1]) m_lock = 1;
      else if (rd && vis[1]) m_lock = 0;
      m_pend = (m_pend & ~(rd ? vis : 8'h00)) | {2'b00, ev};
      if (mwr) m_mask = mdat;
      sz = blk ? 32 : 16;
      if (trst) begin
        m_cnt = 0; m_ovf = 0;
      end else begin
        c = ev[0] ? 0 : m_cnt;
        if (twr) begin
          if (c >= sz) m_ovf = 1;
          else c = c + 1;
        end
        m_cnt = c;
      end
      if (rabort) m_act = 0;
      else if (rflag) m_act = 1;
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every cycle
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] vis;
      bit w;
      vis = m_pend & ~m_mask;
      w = (m_cnt < (blk ? 32 : 16)) && !m_lock;
      chk("R3 R2 R5 R6 model isr_rdata", rdata, vis);
      chk("R4 model irq", {7'd0, irq}, {7'd0, vis != 8'h00});
      chk("R7 model lock", {7'd0, lock}, {7'd0, m_lock});
      chk("R8 model overflow", {7'd0, stat[7]}, {7'd0, m_ovf});
      chk("R9 model write enable", {7'd0, stat[6]}, {7'd0, w});
      chk("R10 model rx active", {7'd0, stat[5]}, {7'd0, m_act});
    end
  end

  task automatic pulse_ev(logic [5:0] v);
    @(negedge clk); ev = v;
    @(negedge clk); ev = '0;
    #1;
  endtask

  task automatic wr_mask(logic [7:0] v);
    @(negedge clk); mwr = 1; mdat = v;
    @(negedge clk); mwr = 0;
    #1;
  endtask

  task automatic do_read(output logic [7:0] val);
    @(negedge clk); rd = 1; #1 val = rdata;
    @(negedge clk); rd = 0;
    #1;
  endtask

  task automatic wr_bytes(int n);
    @(negedge clk); twr = 1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); twr = 0;
    #1;
  endtask

  task automatic pulse_rx(bit f, bit a);
    @(negedge clk); rflag = f; rabort = a;
    @(negedge clk); rflag = 0; rabort = 0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ev = '0; mwr = 0; mdat = '0; rd = 0;
    twr = 0; blk = 0; trst = 0; rflag = 0; rabort = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 reset status", stat, 8'h40);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    chk("R1 reset lock", {7'd0, lock}, 8'h00);
    chk("R1 reset rdata", rdata, 8'h00);

    // all events while masked by reset
    pulse_ev(6'h3F);
    chk("R2 masked events hidden", rdata, 8'h00);
    chk("R4 irq low while masked", {7'd0, irq}, 8'h00);
    chk("R7 underrun locks", {7'd0, lock}, 8'h01);
    chk("R9 locked blocks write", stat, 8'h00);

    // unmask bits 0 and 4
    wr_mask(8'hEE);
    chk("R5 unmasked events visible", rdata, 8'h11);
    chk("R5 unmasked raises irq", {7'd0, irq}, 8'h01);

    do_read(got);
    chk("R3 read returns shown", got, 8'h11);
    chk("R3 shown cleared", rdata, 8'h00);
    chk("R7 masked underrun read keeps lock", {7'd0, lock}, 8'h01);
    wr_mask(8'h00);
    chk("R3 masked bits kept", rdata, 8'h2E);
    do_read(got);
    chk("R3 second read", got, 8'h2E);
    chk("R7 lock released after read", {7'd0, lock}, 8'h00);
    chk("R9 write enable back", stat, 8'h40);

    // event racing a read
    pulse_ev(6'h10);
    @(negedge clk); rd = 1; ev = 6'h10;
    @(negedge clk); rd = 0; ev = '0;
    #1;
    chk("R6 event beats read", rdata, 8'h10);
    do_read(got);
    chk("R6 cleared afterwards", rdata, 8'h00);

    // masked underrun holds lock
    wr_mask(8'h02);
    pulse_ev(6'h02);
    do_read(got);
    chk("R7 masked underrun unreadable", got, 8'h00);
    chk("R7 masked underrun holds lock", {7'd0, lock}, 8'h01);
    wr_mask(8'h00);
    do_read(got);
    chk("R7 unmasked underrun read", got, 8'h02);
    chk("R7 lock cleared", {7'd0, lock}, 8'h00);

    // underrun racing its own read
    pulse_ev(6'h02);
    @(negedge clk); rd = 1; ev = 6'h02;
    @(negedge clk); rd = 0; ev = '0;
    #1;
    chk("R6 R7 new underrun keeps lock", {7'd0, lock}, 8'h01);
    do_read(got);
    chk("R7 lock cleared after race", {7'd0, lock}, 8'h00);

    // transmit fill with 16-byte block
    wr_bytes(15);
    chk("R9 below block size", stat, 8'h40);
    wr_bytes(1);
    chk("R9 block full", stat, 8'h00);
    wr_bytes(1);
    chk("R8 overflow on extra write", stat, 8'h80);
    @(negedge clk); blk = 1; #1;
    chk("R9 larger block reopens", stat, 8'hC0);
    wr_bytes(16);
    chk("R9 large block full", stat, 8'h80);
    pulse_ev(6'h01);
    chk("R8 pool ready keeps overflow", stat, 8'hC0);
    do_read(got);
    chk("R2 transmit ready latched", got, 8'h01);
    @(negedge clk); trst = 1;
    @(negedge clk); trst = 0; #1;
    chk("R8 transmitter reset clears", stat, 8'h40);

    // receiver activity
    pulse_rx(1, 0);
    chk("R10 flag sets active", stat, 8'h60);
    pulse_rx(1, 1);
    chk("R10 abort wins", stat, 8'h40);
    pulse_rx(1, 0);
    pulse_rx(0, 1);
    chk("R10 abort clears", stat, 8'h40);

    repeat (3) @(negedge clk);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule